// File: doc/BRIEF.md
# Two-Wire Serial ROM Responder

This block is the device side of a two-wire serial memory whose bus lines are driven by software through a register. Each write to that register is applied as an update strobe that carries new clock and data levels. The block registers the levels and compares them with the ones it stored before. From that comparison it finds bus conditions, rising clock edges and data bits. It acknowledges a command byte and then a word address. It then fetches one byte from a 256-entry constant table.

The fetched byte is returned MSB first. It appears on the data line during the address phase of the next transaction that carries a read command. The data level that software reads back is always the level the block registered last. That level is the host's own level, except on the bits the block pulls low or drives itself.

Top module: `i2c_rom_slave`

## Requirements
- R1: After reset the reported data line is high and no transfer is in progress.
- R2: Until a START has been seen, clock pulses and data changes have no effect. No acknowledge is given, and the byte held for read-back is unchanged.
- R3: A START is the data line falling while the clock line stays high. After a START, eight accepted bits form the command byte, sent MSB first. On the ninth rising clock edge the block drives the data line low.
- R4: After the command acknowledge, eight accepted bits form the word address, sent MSB first. On the following rising clock edge the block drives the data line low.
- R5: Once the address is complete, the block loads the table byte at that address. The table byte at address A is A with its two nibbles swapped, XORed with 0x5A. When the command byte's bit 0 is 1 (read), each address-phase rising edge drives the data line with the MSB of the held byte, and the held byte then shifts left by one.
- R6: When the command byte's bit 0 is 0 (write), the data line reported during the address phase follows the host's level.
- R7: A rising clock edge that arrives in the same update as a change of the data line is not taken as a bit, and the bit count does not advance.
- R8: A START in the middle of a transfer restarts the count, so the command acknowledge comes only after eight further accepted bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd | input | 1 | Update strobe: sample scl_in and sda_in this cycle |
| scl_in | input | 1 | Clock line level written by the host |
| sda_in | input | 1 | Data line level written by the host |
| sda_out | output | 1 | Registered data line level, as read back by the host |

## Verification
The main function is tried with a series of transactions that pass through several addresses, each at a bit pattern of its own. One write-command transaction leaves the host's bits visible on the data line. Chained read-command transactions return the byte fetched by the transaction before, and this separates the fetch from the shift-out. Further directed patterns cover the following: clocking before any START, a data change that lands on a clock rise, and a repeated START part-way through a command. The first shows that idle activity is ignored. The second shows that a bit is rejected when its data changes on the edge. The third shows that the restart really resets the bit count.

// File: rtl/i2c_rom_slave.sv
module i2c_rom_slave #(
  parameter logic [7:0] KEY = 8'h5A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_out
);
  localparam int BW = 8;
  localparam logic [4:0] CMD_END = 5'(BW + 1);
  localparam logic [4:0] ADR_END = 5'(2 * BW + 1);

  logic       scl_q, sda_q, ack;
  logic [4:0] tick;
  logic [7:0] cmd, addr, dat;

  logic       n_sda, n_ack;
  logic [4:0] n_tick;
  logic [7:0] n_cmd, n_addr, n_dat;

  function automatic logic [7:0] rom_byte(input logic [7:0] a);
    return {a[3:0], a[7:4]} ^ KEY;
  endfunction

  wire bus_cond = scl_q && scl_in && (sda_q != sda_in);
  wire rise     = !scl_q && scl_in;
  wire [7:0] addr_sh = {addr[6:0], sda_in};

  always_comb begin
    n_tick = tick; n_cmd = cmd; n_addr = addr; n_dat = dat;
    n_ack = ack; n_sda = sda_in;
    if (bus_cond) begin
      if (!sda_in) begin
        n_tick = 5'd1;
        n_cmd  = '0;
      end
    end else if (tick == 5'd0 && !ack) begin
      n_tick = tick;
    end else if (rise) begin
      if (ack) begin
        n_sda = 1'b0;
        n_ack = 1'b0;
      end else if (sda_q == sda_in) begin
        if (tick < CMD_END) begin
          n_cmd  = {cmd[6:0], sda_in};
          n_tick = tick + 5'd1;
          if (tick == CMD_END - 5'd1) n_ack = 1'b1;
        end else if (tick < ADR_END) begin
          if (cmd[0]) n_sda = dat[7];
          n_addr = addr_sh;
          n_dat  = {dat[6:0], 1'b0};
          if (tick == ADR_END - 5'd1) begin
            n_dat  = rom_byte(addr_sh);
            n_ack  = 1'b1;
            n_tick = 5'd0;
          end else begin
            n_tick = tick + 5'd1;
          end
        end else begin
          n_sda = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1; sda_q <= 1'b1; ack <= 1'b0;
      tick <= '0; cmd <= '0; addr <= '0; dat <= '0;
    end else if (upd) begin
      scl_q <= scl_in; sda_q <= n_sda; ack <= n_ack;
      tick <= n_tick; cmd <= n_cmd; addr <= n_addr; dat <= n_dat;
    end
  end

  assign sda_out = sda_q;

  a_r1_tick_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tick < ADR_END);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && tick == 5'd0 && !ack && !(scl_q && scl_in && sda_q && !sda_in))
    |=> (tick == 5'd0 && $stable(dat)));

  a_r3_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && ack && !scl_q && scl_in) |=> (!sda_out && !ack));

  a_r5_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && rise && !ack && sda_q == sda_in && tick == ADR_END - 5'd1)
    |=> (ack && tick == 5'd0));

  a_r7_glitch_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && rise && !ack && tick != 5'd0 && sda_q != sda_in) |=> $stable(tick));

  a_r8_start_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && scl_q && scl_in && sda_q && !sda_in) |=> (tick == 5'd1 && cmd == 8'd0));
endmodule

// File: tb/i2c_rom_slave_tb.sv
module i2c_rom_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 6;
  localparam logic [15:0] VEC [N] = '{
    {8'h00, 8'h5A}, {8'h12, 8'h7B}, {8'hFF, 8'hA5},
    {8'h80, 8'h52}, {8'h3C, 8'h99}, {8'h01, 8'h4A}
  };

  logic clk = 0, rst_n = 0, upd = 0, scl = 1, sda = 1;
  wire  sda_out;
  int   checks = 0, errors = 0;
  bit   done = 0;

  i2c_rom_slave u_dut (.clk(clk), .rst_n(rst_n), .upd(upd),
                       .scl_in(scl), .sda_in(sda), .sda_out(sda_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic step(input logic c, input logic d);
    @(negedge clk); scl = c; sda = d; upd = 1;
    @(negedge clk); upd = 0;
  endtask

  task automatic bit_clk(input logic b, output logic got);
    step(0, b); step(1, b); got = sda_out; step(0, b);
  endtask

  task automatic do_start(); step(1, 1); step(1, 0); step(0, 0); endtask
  task automatic do_stop();  step(0, 0); step(1, 0); step(1, 1); endtask

  task automatic xfer(input logic [7:0] c, input logic [7:0] a,
                      output logic [7:0] rd, output logic ackc, output logic acka);
    logic g;
    do_start();
    for (int i = 7; i >= 0; i--) bit_clk(c[i], g);
    bit_clk(1, ackc);
    for (int i = 7; i >= 0; i--) begin bit_clk(a[i], g); rd[i] = g; end
    bit_clk(1, acka);
    do_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic ac, aa, g;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset sda_out", 8'(sda_out), 8'h01);

    // R6 write command: address bits echo the host
    xfer(8'hA0, VEC[0][15:8], rd, ac, aa);
    check("R3 command ack", 8'(ac), 8'h00);
    check("R4 address ack", 8'(aa), 8'h00);
    check("R6 write echoes host", rd, VEC[0][15:8]);

    // R5 chained reads: each returns the byte fetched by the previous transfer
    for (int i = 1; i <= N; i++) begin
      xfer(8'hA1, (i < N) ? VEC[i][15:8] : 8'h00, rd, ac, aa);
      check("R3 command ack (read)", 8'(ac), 8'h00);
      check("R4 address ack (read)", 8'(aa), 8'h00);
      check("R5 read-back byte", rd, VEC[i-1][7:0]);
    end

    // R2 activity without START is ignored
    for (int i = 0; i < 10; i++) begin
      bit_clk(1, g);
      check("R2 no ack before START", 8'(g), 8'h01);
    end
    bit_clk(0, g);
    xfer(8'hA1, 8'h12, rd, ac, aa);
    check("R2 held byte unchanged", rd, 8'h5A);

    // R7 data change on the clock rise is rejected
    do_start();
    for (int i = 7; i >= 1; i--) bit_clk(logic'(8'hA1 >> i), g);
    step(0, 0); step(1, 1); step(0, 1);
    bit_clk(1, g);
    check("R7 glitch not counted", 8'(g), 8'h01);
    bit_clk(1, g);
    check("R7 ack after eighth good bit", 8'(g), 8'h00);
    for (int i = 7; i >= 0; i--) begin bit_clk(8'h3C >> i, g); rd[i] = g; end
    bit_clk(1, g);
    do_stop();
    check("R7 read-back after glitch", rd, 8'h7B);

    // R8 repeated START restarts the count
    do_start();
    bit_clk(1, g); bit_clk(0, g); bit_clk(1, g); bit_clk(0, g);
    step(0, 1); step(1, 1); step(1, 0); step(0, 0);
    for (int i = 7; i >= 0; i--) begin
      bit_clk(logic'(8'hA1 >> i), g);
      check("R8 no early ack", 8'(g), 8'(logic'(8'hA1 >> i)));
    end
    bit_clk(1, g);
    check("R8 ack after restart", 8'(g), 8'h00);
    for (int i = 7; i >= 0; i--) begin bit_clk(1'b0, g); rd[i] = g; end
    bit_clk(1, g);
    do_stop();
    check("R8 read-back after restart", rd, 8'h99);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule